// File: doc/BRIEF.md
# SPI Select-Event and Interrupt Status Controller

This block collects the event flags and interrupt enables of an SPI peripheral and turns them into one interrupt line. It watches a set of slave-select lines that have already been polarity-corrected (1 means the select is active), the master idle condition, and the stall condition. From these it keeps two sticky event flags. One records that some select has just become active. The other records that the selects have all gone quiet after at least one of them was active.

Software reaches the block through a small word-addressed register port. Reads are combinational on the address. Writes take effect at the next clock edge. There are four locations. The status word holds the two sticky flags, which are cleared by writing 1, and two live bits for stall and master idle. The enable word is written through a set location and a separate clear location. The fourth location shows each event ANDed with its enable. The interrupt output is the OR of those masked bits. The shift engine and the FIFOs live elsewhere and only feed their idle, stall and select signals in.

Top module: `spi_stat_irq`

## Requirements
- R1: After reset both sticky flags and all three enables are 0, every register reads 0 except the live bits, and `irq_o` is 0 while the master is not idle.
- R2: The select-active flag (status bit 4) reads 1 after the second rising clock edge that follows any select input going from 0 to 1. A select that stays at 1 does not set the flag again after software clears it.
- R3: The all-quiet flag (status bit 5) reads 1 after the second rising clock edge that follows the last active select returning to 0. A change from two active selects to one active select does not set it.
- R4: A write to address 0 clears flag bits 4 and 5 where the written data has a 1. Written zeros leave the flags unchanged.
- R5: If a flag's hardware set condition and a software clear of that flag fall in the same cycle, the flag is 1 afterwards.
- R6: A write to address 1 sets each enable whose bit holds a 1. Bit 4 is the select-active enable, bit 5 the all-quiet enable and bit 8 the idle enable. Zeros leave enables unchanged. Reading address 1 returns the enables in those positions.
- R7: A write to address 2 clears each enable whose bit holds a 1. Zeros leave enables unchanged. Address 2 always reads 0.
- R8: Status bit 6 follows `stall_i` in the same cycle. Status bit 8 is 1 exactly when `hold_empty_i` is 1 and `shift_busy_i` is 0, also in the same cycle.
- R9: Address 3 reads bit 4 = flag4 AND enable4, bit 5 = flag5 AND enable5, and bit 8 = idle AND enable8, with all other bits 0. `irq_o` is the OR of those three bits.
- R10: Status bits other than 4 and 5 are not writable, and writes to address 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_active_i | input | NUM_SEL | Polarity-corrected select lines, 1 = active |
| hold_empty_i | input | 1 | Transmit holding stage empty |
| shift_busy_i | input | 1 | Shifter currently moving data |
| stall_i | input | 1 | Live stall condition |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address: 0 status, 1 enable set, 2 enable clear, 3 masked status |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for `reg_addr_i` |
| irq_o | output | 1 | Peripheral interrupt |

## Verification
Select events pass through two register stages, a sample stage and a history stage. A flag is therefore due after the second rising edge following the input change, and the bench checks it both one edge early, when it must still be clear, and at the due edge. Register writes show on a read after one edge. The live stall and idle bits, the masked view and `irq_o` are due in the same cycle as their inputs. The bench drives all inputs on the falling edge and updates its reference model at the rising edge from the values it drove. It samples a settled read just after the falling edge, so every comparison is aligned to the edge count above.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int BIT_SEL_ON  = 4;
    localparam int BIT_SEL_OFF = 5;
    localparam int BIT_STALL   = 6;
    localparam int BIT_IDLE    = 8;
    localparam int MIN_DATA_W  = BIT_IDLE + 1;

    typedef enum logic [1:0] {
        ADDR_STATUS = 2'd0,
        ADDR_EN_SET = 2'd1,
        ADDR_EN_CLR = 2'd2,
        ADDR_MASKED = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic sel_on;
        logic sel_off;
    } evt_t;

    typedef struct packed {
        logic sel_on;
        logic sel_off;
        logic idle;
    } irq_en_t;

endpackage

// File: rtl/spi_sel_edge.sv
module spi_sel_edge #(
    parameter int NUM_SEL = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SEL-1:0] sel_active_i,
    output logic               on_evt_o,
    output logic               off_evt_o
);

    typedef struct packed {
        logic [NUM_SEL-1:0] samp;
        logic [NUM_SEL-1:0] hist;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic [NUM_SEL-1:0] rise_vec;

    // One rising detector per select line
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_rise
        assign rise_vec[g] = st_q.samp[g] & ~st_q.hist[g];
    end

    always_comb begin
        st_d      = st_q;
        st_d.samp = sel_active_i;
        st_d.hist = st_q.samp;
        on_evt_o  = |rise_vec;
        off_evt_o = (|st_q.hist) & ~(|st_q.samp);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2: an assert event needs an active sampled select
    a_r2_on_has_active: assert property (@(posedge clk) disable iff (!rst_n)
        on_evt_o |-> (st_q.samp != '0));

    // R3: a release event means every sampled select is idle
    a_r3_off_all_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        off_evt_o |-> (st_q.samp == '0));

    // R3: on and off events cannot coincide
    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(on_evt_o && off_evt_o));

endmodule

// File: rtl/spi_evt_flags.sv
module spi_evt_flags
    import spi_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  evt_t set_i,
    input  evt_t clr_i,
    output evt_t flags_o
);

    evt_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        // Software clear first, hardware set overrides it
        if (clr_i.sel_on)  flg_d.sel_on  = 1'b0;
        if (clr_i.sel_off) flg_d.sel_off = 1'b0;
        if (set_i.sel_on)  flg_d.sel_on  = 1'b1;
        if (set_i.sel_off) flg_d.sel_off = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flags_o = flg_q;

    // R5: a hardware set always lands
    a_r5_on_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i.sel_on |=> flags_o.sel_on);
    a_r5_off_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i.sel_off |=> flags_o.sel_off);

    // R4: an uncontested clear drops the flag
    a_r4_on_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i.sel_on && !set_i.sel_on) |=> !flags_o.sel_on);

    // R4: without set or clear the flag holds
    a_r4_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i.sel_off && !set_i.sel_off) |=> $stable(flags_o.sel_off));

endmodule

// File: rtl/spi_irq_en.sv
module spi_irq_en
    import spi_irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  irq_en_t set_i,
    input  irq_en_t clr_i,
    output irq_en_t en_o
);

    irq_en_t en_d, en_q;

    always_comb begin
        en_d = (en_q | set_i) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en_o = en_q;

    // R6: a set request turns the enable on
    a_r6_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i.idle && !clr_i.idle) |=> en_o.idle);

    // R7: a clear request turns the enable off
    a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i.sel_on |=> !en_o.sel_on);

    // R6: with no request the enables hold
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(en_o));

endmodule

// File: rtl/spi_stat_irq.sv
module spi_stat_irq
    import spi_irq_pkg::*;
#(
    parameter int NUM_SEL = 4,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SEL-1:0] sel_active_i,
    input  logic               hold_empty_i,
    input  logic               shift_busy_i,
    input  logic               stall_i,
    input  logic               reg_wr_i,
    input  logic [1:0]         reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_o
);

    localparam int ADDR_W = 2;

    evt_t    evt_set, evt_clr, flags;
    irq_en_t en_set, en_clr, en;
    logic    on_evt, off_evt;
    logic    idle_live;
    logic    wr_status, wr_en_set, wr_en_clr;
    logic [2:0] masked;

    spi_sel_edge #(.NUM_SEL(NUM_SEL)) u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_active_i(sel_active_i),
        .on_evt_o    (on_evt),
        .off_evt_o   (off_evt)
    );

    always_comb begin
        wr_status = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_STATUS));
        wr_en_set = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_EN_SET));
        wr_en_clr = reg_wr_i && (reg_addr_i == ADDR_W'(ADDR_EN_CLR));

        evt_set.sel_on  = on_evt;
        evt_set.sel_off = off_evt;
        evt_clr.sel_on  = wr_status && reg_wdata_i[BIT_SEL_ON];
        evt_clr.sel_off = wr_status && reg_wdata_i[BIT_SEL_OFF];

        en_set.sel_on  = wr_en_set && reg_wdata_i[BIT_SEL_ON];
        en_set.sel_off = wr_en_set && reg_wdata_i[BIT_SEL_OFF];
        en_set.idle    = wr_en_set && reg_wdata_i[BIT_IDLE];
        en_clr.sel_on  = wr_en_clr && reg_wdata_i[BIT_SEL_ON];
        en_clr.sel_off = wr_en_clr && reg_wdata_i[BIT_SEL_OFF];
        en_clr.idle    = wr_en_clr && reg_wdata_i[BIT_IDLE];
    end

    spi_evt_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_set),
        .clr_i  (evt_clr),
        .flags_o(flags)
    );

    spi_irq_en u_en (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(en_set),
        .clr_i(en_clr),
        .en_o (en)
    );

    always_comb begin
        idle_live = hold_empty_i & ~shift_busy_i;
        masked[0] = flags.sel_on  & en.sel_on;
        masked[1] = flags.sel_off & en.sel_off;
        masked[2] = idle_live     & en.idle;
        irq_o     = |masked;

        reg_rdata_o = '0;
        unique case (reg_addr_i)
            ADDR_W'(ADDR_STATUS): begin
                reg_rdata_o[BIT_SEL_ON]  = flags.sel_on;
                reg_rdata_o[BIT_SEL_OFF] = flags.sel_off;
                reg_rdata_o[BIT_STALL]   = stall_i;
                reg_rdata_o[BIT_IDLE]    = idle_live;
            end
            ADDR_W'(ADDR_EN_SET): begin
                reg_rdata_o[BIT_SEL_ON]  = en.sel_on;
                reg_rdata_o[BIT_SEL_OFF] = en.sel_off;
                reg_rdata_o[BIT_IDLE]    = en.idle;
            end
            ADDR_W'(ADDR_EN_CLR): reg_rdata_o = '0;
            default: begin
                reg_rdata_o[BIT_SEL_ON]  = masked[0];
                reg_rdata_o[BIT_SEL_OFF] = masked[1];
                reg_rdata_o[BIT_IDLE]    = masked[2];
            end
        endcase
    end

    // R9: the interrupt needs at least one enable
    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (en != '0));

    // R10: a write to the masked view leaves flags and enables alone
    a_r10_masked_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_addr_i == ADDR_W'(ADDR_MASKED) && !on_evt && !off_evt)
        |=> ($stable(flags) && $stable(en)));

    // R1: nothing is pending or enabled right after reset
    a_r1_reset_clear: assert property (@(posedge clk)
        $rose(rst_n) |-> (flags == '0 && en == '0));

endmodule

// File: tb/spi_stat_irq_test.sv
module spi_stat_irq_test;

    localparam int NS = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] sel = '0;
    logic          hold_empty = 1'b0;
    logic          shift_busy = 1'b0;
    logic          stall = 1'b0;
    logic          wr = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference state
    logic [NS-1:0] m_samp = '0, m_hist = '0;
    logic m_on = 0, m_off = 0, m_en_on = 0, m_en_off = 0, m_en_idle = 0;

    spi_stat_irq #(.NUM_SEL(NS), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .sel_active_i(sel),
        .hold_empty_i(hold_empty), .shift_busy_i(shift_busy), .stall_i(stall),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] exp_rd(input logic [1:0] a);
        logic [DW-1:0] v;
        logic idle;
        v = '0;
        idle = hold_empty & ~shift_busy;
        case (a)
            2'd0: begin v[4] = m_on; v[5] = m_off; v[6] = stall; v[8] = idle; end
            2'd1: begin v[4] = m_en_on; v[5] = m_en_off; v[8] = m_en_idle; end
            2'd2: v = '0;
            default: begin
                v[4] = m_on & m_en_on; v[5] = m_off & m_en_off; v[8] = idle & m_en_idle;
            end
        endcase
        return v;
    endfunction

    function automatic logic exp_irq();
        return (m_on & m_en_on) | (m_off & m_en_off)
             | (hold_empty & ~shift_busy & m_en_idle);
    endfunction

    // One rising edge: update the model from driven values, then go to the falling edge
    task automatic tick();
        logic rise, fall;
        @(posedge clk);
        if (!rst_n) begin
            m_samp = '0; m_hist = '0; m_on = 0; m_off = 0;
            m_en_on = 0; m_en_off = 0; m_en_idle = 0;
        end else begin
            rise = |(m_samp & ~m_hist);
            fall = (|m_hist) & ~(|m_samp);
            if (wr && addr == 2'd0) begin
                if (wdata[4]) m_on = 0;
                if (wdata[5]) m_off = 0;
            end
            if (rise) m_on = 1;
            if (fall) m_off = 1;
            if (wr && addr == 2'd1) begin
                if (wdata[4]) m_en_on = 1;
                if (wdata[5]) m_en_off = 1;
                if (wdata[8]) m_en_idle = 1;
            end
            if (wr && addr == 2'd2) begin
                if (wdata[4]) m_en_on = 0;
                if (wdata[5]) m_en_off = 0;
                if (wdata[8]) m_en_idle = 0;
            end
            m_hist = m_samp;
            m_samp = sel;
        end
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [1:0] a);
        logic [DW-1:0] e;
        logic ei;
        wr = 1'b0;
        addr = a;
        #1;
        e = exp_rd(a);
        ei = exp_irq();
        n_chk++;
        if (rdata !== e || irq !== ei) begin
            n_bad++;
            $display("FAIL %s addr %0d: rdata=%h irq=%b expected rdata=%h irq=%b",
                     req, a, rdata, irq, e, ei);
        end
    endtask

    task automatic write(input logic [1:0] a, input logic [DW-1:0] d);
        wr = 1'b1; addr = a; wdata = d;
        tick();
        wr = 1'b0; wdata = '0;
    endtask

    task automatic check_all(input string req);
        for (int a = 0; a < 4; a++) check(req, 2'(a));
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        tick(); tick();
        check_all("R1 reset");
        rst_n = 1'b1;
        tick();
        check_all("R1 after release");

        // R2: single select rises; flag due after second edge
        sel = 4'b0001;
        tick(); check("R2 one edge early", 2'd0);
        tick(); check("R2 flag set", 2'd0);
        write(2'd0, 32'h10);
        tick(); tick(); check("R2 held select no re-set", 2'd0);
        sel = 4'b0011;
        tick(); tick(); check("R2 second select sets again", 2'd0);

        // R3: two active to one active does not set
        sel = 4'b0010;
        tick(); tick(); check("R3 partial release", 2'd0);
        sel = 4'b0000;
        tick(); check("R3 one edge early", 2'd0);
        tick(); check("R3 all quiet set", 2'd0);

        // R4: zeros do nothing, ones clear
        write(2'd0, 32'h0);  check("R4 zero write", 2'd0);
        write(2'd0, 32'h20); check("R4 clear bit5", 2'd0);
        write(2'd0, 32'h10); check("R4 clear bit4", 2'd0);

        // R10: non-flag bits and the masked location are inert
        sel = 4'b1000; tick(); tick();
        write(2'd0, 32'hFFFF_FFCF); check("R10 status other bits", 2'd0);
        write(2'd3, 32'hFFFF_FFFF); check_all("R10 masked write");

        // R6 / R7: enable set and clear
        write(2'd1, 32'h0);   check("R6 zero set", 2'd1);
        write(2'd1, 32'h130); check("R6 set all", 2'd1);
        write(2'd2, 32'h0);   check("R7 zero clear", 2'd1);
        write(2'd2, 32'h10);  check("R7 clear bit4", 2'd1);
        check("R7 clear reads zero", 2'd2);
        write(2'd1, 32'h10);

        // R8 / R9: live bits and masking across idle combinations
        for (int k = 0; k < 8; k++) begin
            hold_empty = k[0]; shift_busy = k[1]; stall = k[2];
            check("R8 live bits", 2'd0);
            check("R9 masked view", 2'd3);
        end
        hold_empty = 0; shift_busy = 0; stall = 0;

        // R5: hardware set and software clear together
        sel = 4'b0000; tick(); tick();
        write(2'd0, 32'h30);
        sel = 4'b0100; tick();
        write(2'd0, 32'h10);
        check("R5 set wins over clear", 2'd0);
        check("R9 irq with set flag", 2'd3);

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            sel = ($urandom % 3 == 0) ? 4'($urandom) : sel;
            hold_empty = r[0]; shift_busy = r[1] & r[2]; stall = r[3];
            wr = (r[6:4] < 3'd3);
            addr = r[9:8];
            wdata = {$urandom} & 32'h0000_0130 | (r[10] ? 32'hFFFF_FECF : 32'h0);
            tick();
            check("R9 random", 2'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule